// File: doc/BRIEF.md
# Semaphore-Metered Command Chain Channel

This block is one channel of a descriptor-driven DMA engine. Software first writes the address of a command descriptor into the next-command register. It then adds a count to the channel semaphore. While the semaphore is non-zero and the chain has not been closed, the channel reads a three-word descriptor from memory and starts a transfer. The first word is the pointer to the next descriptor, the second is the control word, and the third is the buffer address. Once the transfer has finished, the channel follows the chain pointer.

The data movement itself is modelled by a fixed-latency transfer timer. A single-cycle `xfer_go` pulse carries the buffer address out, and the command counts as finished a fixed number of cycles later. Each finished command produces a one-cycle `cmd_done` pulse. A command may optionally take one unit off the semaphore. The semaphore therefore tracks how many commands are still to be finished, and software can read it back at any time through the register port.

Top module: `cmdchain_engine`

## Requirements
- R1: After the next-command address A is written and the semaphore is non-zero, the channel reads the descriptor words at A, A+4 and A+8 in that order, with one request per word over the valid/ready read port. Word A+8 is the buffer address. The transfer then begins with a one-cycle `xfer_go` pulse while `xfer_buf` equals that buffer address.
- R2: No descriptor fetch starts while the semaphore is zero. Once software adds a non-zero count, fetching resumes from the current next-command address.
- R3: When a command finishes, the semaphore drops by one only if bit 1 of its control word is set. The semaphore never goes below zero.
- R4: When bit 0 of a finished command's control word is set, the next-command register takes the value of that command's first word. The next fetch starts from that address.
- R5: A finished command with control bit 0 clear closes the chain, even if the semaphore is still non-zero. The channel then stays idle until software rewrites the next-command address.
- R6: A write to the semaphore adds the written value to the current count, whether the channel is idle or running. The result saturates at 2^SEMA_W-1.
- R7: `cmd_done` is a one-cycle pulse for every finished command, whether or not the command decrements the semaphore. It rises exactly XFER_LAT cycles after the command's `xfer_go`.
- R8: A register read returns the next-command address when `reg_rd_sel` is 0 and the semaphore count when it is 1. The data appears one cycle after the select is presented. Both values are zero after reset.
- R9: While `mrd_valid` is high and `mrd_ready` is low, the request and its address stay unchanged. Stalls alter neither the fetched words nor the commands executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 next-command address, 1 semaphore add |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_sel | input | 1 | Read select: 0 next-command address, 1 semaphore |
| reg_rd_data | output | DATA_W | Registered read data |
| mrd_valid | output | 1 | Descriptor read request valid |
| mrd_addr | output | ADDR_W | Descriptor word byte address |
| mrd_ready | input | 1 | Memory accepts the request |
| mrd_rvalid | input | 1 | Read data valid |
| mrd_rdata | input | DATA_W | Read data |
| xfer_go | output | 1 | Transfer start pulse |
| xfer_buf | output | ADDR_W | Buffer address of the current command |
| cmd_done | output | 1 | Command finished pulse |
| busy | output | 1 | Channel running or about to fetch |

## Verification
The assertions take two things for granted about the memory port: it returns exactly one `mrd_rvalid` beat for each accepted request, and that beat never comes before the request is accepted. They also assume software does not rewrite the next-command address while the channel is busy. The bench memory model answers one cycle after each accepted request, and in the stall scenario it toggles `mrd_ready`. The bench writes the next-command register only after `busy` has stayed low for several cycles. Semaphore additions made while the channel is running land only in the window between a transfer start and its completion.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int CTL_CHAIN_BIT  = 0;
  localparam int CTL_DEC_BIT    = 1;
  localparam int DESC_WORDS     = 3;
  localparam int WORD_BYTES     = 4;
  localparam int IDX_NEXT       = 0;
  localparam int IDX_CTL        = 1;
  localparam int IDX_BUF        = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EXEC
  } seq_state_t;
endpackage

// File: rtl/cce_sema.sv
module cce_sema #(
  parameter int DATA_W = 32,
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en,
  input  logic [DATA_W-1:0] add_val,
  input  logic              dec_req,
  output logic [SEMA_W-1:0] count,
  output logic              nonzero
);
  localparam int SUM_W = ((DATA_W > SEMA_W) ? DATA_W : SEMA_W) + 1;
  localparam logic [SUM_W-1:0] MAX_VAL = SUM_W'({SEMA_W{1'b1}});

  logic [SUM_W-1:0] sum;
  logic             dec_ok;

  assign dec_ok = dec_req && (count != '0);

  always_comb begin
    sum = SUM_W'(count);
    if (add_en) sum = sum + SUM_W'(add_val);
    if (dec_ok) sum = sum - SUM_W'(1);
    if (sum > MAX_VAL) sum = MAX_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= sum[SEMA_W-1:0];
  end

  assign nonzero = (count != '0);
endmodule

// File: rtl/cce_xfer.sv
module cce_xfer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic go,
  output logic done
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      go  <= 1'b0;
    end else begin
      go <= start;
      if (start)            cnt <= CNT_W'(LAT);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/cce_seq.sv
module cce_seq
  import cce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic              sema_nz,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic              mrd_valid,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrd_ready,
  input  logic              mrd_rvalid,
  input  logic [DATA_W-1:0] mrd_rdata,
  input  logic              xfer_done,
  output logic              fetch_start,
  output logic              xfer_start,
  output logic              cmd_fin,
  output logic              fin_chain,
  output logic              fin_dec,
  output logic [ADDR_W-1:0] fin_next,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              cmd_done,
  output logic              idle
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] widx;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] w_next;
  logic [1:0]        w_ctl;
  logic [ADDR_W-1:0] w_buf;
  logic              done_q;

  assign idle        = (state == ST_IDLE);
  assign fetch_start = idle && armed && sema_nz;
  assign mrd_valid   = (state == ST_REQ);
  assign mrd_addr    = addr_q;
  assign xfer_start  = (state == ST_WAIT) && mrd_rvalid && (widx == LAST_IDX);
  assign cmd_fin     = (state == ST_EXEC) && xfer_done;
  assign fin_chain   = w_ctl[CTL_CHAIN_BIT];
  assign fin_dec     = w_ctl[CTL_DEC_BIT];
  assign fin_next    = w_next;
  assign buf_addr    = w_buf;
  assign cmd_done    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      widx   <= '0;
      addr_q <= '0;
      w_next <= '0;
      w_ctl  <= '0;
      w_buf  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fetch_start) begin
            addr_q <= nxt_addr;
            widx   <= '0;
            state  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mrd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mrd_rvalid) begin
            case (int'(widx))
              IDX_NEXT: w_next <= mrd_rdata[ADDR_W-1:0];
              IDX_CTL:  w_ctl  <= {mrd_rdata[CTL_DEC_BIT], mrd_rdata[CTL_CHAIN_BIT]};
              IDX_BUF:  w_buf  <= mrd_rdata[ADDR_W-1:0];
              default:  ;
            endcase
            if (widx == LAST_IDX) begin
              state <= ST_EXEC;
            end else begin
              widx   <= widx + IDX_W'(1);
              addr_q <= addr_q + ADDR_W'(WORD_BYTES);
              state  <= ST_REQ;
            end
          end
        end
        ST_EXEC: begin
          if (xfer_done) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdchain_engine.sv
module cmdchain_engine #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SEMA_W   = 8,
  parameter int XFER_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              reg_rd_sel,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              mrd_valid,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic              mrd_ready,
  input  logic              mrd_rvalid,
  input  logic [DATA_W-1:0] mrd_rdata,
  output logic              xfer_go,
  output logic [ADDR_W-1:0] xfer_buf,
  output logic              cmd_done,
  output logic              busy
);
  logic [ADDR_W-1:0] nxt_q;
  logic              armed;
  logic              nxt_wr;
  logic              sema_add;
  logic [SEMA_W-1:0] sema_cnt;
  logic              sema_nz;
  logic              fetch_start;
  logic              xfer_start;
  logic              xfer_done;
  logic              cmd_fin;
  logic              fin_chain;
  logic              fin_dec;
  logic [ADDR_W-1:0] fin_next;
  logic              seq_idle;

  assign nxt_wr   = reg_wr_en && !reg_wr_sel;
  assign sema_add = reg_wr_en &&  reg_wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_q <= '0;
      armed <= 1'b0;
    end else if (nxt_wr) begin
      nxt_q <= reg_wr_data[ADDR_W-1:0];
      armed <= 1'b1;
    end else if (cmd_fin) begin
      if (fin_chain) nxt_q <= fin_next;
      else           armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rd_data <= '0;
    else     reg_rd_data <= reg_rd_sel ? DATA_W'(sema_cnt) : DATA_W'(nxt_q);
  end

  assign busy = !seq_idle || (armed && sema_nz);

  cce_sema #(.DATA_W(DATA_W), .SEMA_W(SEMA_W)) u_sema (
    .clk     (clk),
    .rst     (rst),
    .add_en  (sema_add),
    .add_val (reg_wr_data),
    .dec_req (cmd_fin && fin_dec),
    .count   (sema_cnt),
    .nonzero (sema_nz)
  );

  cce_xfer #(.LAT(XFER_LAT)) u_xfer (
    .clk   (clk),
    .rst   (rst),
    .start (xfer_start),
    .go    (xfer_go),
    .done  (xfer_done)
  );

  cce_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .armed       (armed),
    .sema_nz     (sema_nz),
    .nxt_addr    (nxt_q),
    .mrd_valid   (mrd_valid),
    .mrd_addr    (mrd_addr),
    .mrd_ready   (mrd_ready),
    .mrd_rvalid  (mrd_rvalid),
    .mrd_rdata   (mrd_rdata),
    .xfer_done   (xfer_done),
    .fetch_start (fetch_start),
    .xfer_start  (xfer_start),
    .cmd_fin     (cmd_fin),
    .fin_chain   (fin_chain),
    .fin_dec     (fin_dec),
    .fin_next    (fin_next),
    .buf_addr    (xfer_buf),
    .cmd_done    (cmd_done),
    .idle        (seq_idle)
  );
endmodule

// File: rtl/cce_checker.sv
module cce_checker #(
  parameter int ADDR_W = 32,
  parameter int SEMA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_start,
  input logic [SEMA_W-1:0] sema_cnt,
  input logic              sema_add,
  input logic              cmd_done,
  input logic              cmd_fin,
  input logic              fin_chain,
  input logic              nxt_wr,
  input logic              armed,
  input logic              mrd_valid,
  input logic              mrd_ready,
  input logic [ADDR_W-1:0] mrd_addr,
  input logic              xfer_go
);
  p_start_needs_count_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_start |-> (sema_cnt != '0));

  p_drop_only_on_done_r3: assert property (@(posedge clk) disable iff (rst)
    (sema_cnt < $past(sema_cnt)) |-> cmd_done);

  p_drop_by_one_r3: assert property (@(posedge clk) disable iff (rst)
    (sema_cnt < $past(sema_cnt)) |-> (sema_cnt == $past(sema_cnt) - SEMA_W'(1)));

  p_no_wrap_on_add_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(sema_add) && !cmd_done) |-> (sema_cnt >= $past(sema_cnt)));

  p_chain_end_disarms_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_fin && !fin_chain && !nxt_wr) |=> !armed);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  p_go_single_r1: assert property (@(posedge clk) disable iff (rst)
    xfer_go |=> !xfer_go);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));
endmodule

bind cmdchain_engine cce_checker #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_start (fetch_start),
  .sema_cnt    (sema_cnt),
  .sema_add    (sema_add),
  .cmd_done    (cmd_done),
  .cmd_fin     (cmd_fin),
  .fin_chain   (fin_chain),
  .nxt_wr      (nxt_wr),
  .armed       (armed),
  .mrd_valid   (mrd_valid),
  .mrd_ready   (mrd_ready),
  .mrd_addr    (mrd_addr),
  .xfer_go     (xfer_go)
);

// File: tb/sim_cmdchain_engine.sv
module sim_cmdchain_engine;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 8;
  localparam int LAT = 4;
  localparam logic [31:0] C_CHAIN = 32'h1;
  localparam logic [31:0] C_DEC   = 32'h2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0, reg_wr_sel = 1'b0, reg_rd_sel = 1'b0;
  logic [DW-1:0] reg_wr_data = '0;
  logic [DW-1:0] reg_rd_data;
  logic mrd_valid, mrd_ready, mrd_rvalid;
  logic [AW-1:0] mrd_addr;
  logic [DW-1:0] mrd_rdata;
  logic xfer_go, cmd_done, busy;
  logic [AW-1:0] xfer_buf;

  always #2 clk = ~clk;

  cmdchain_engine #(.ADDR_W(AW), .DATA_W(DW), .SEMA_W(SW), .XFER_LAT(LAT)) u0 (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .mrd_valid(mrd_valid), .mrd_addr(mrd_addr), .mrd_ready(mrd_ready),
    .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
    .xfer_go(xfer_go), .xfer_buf(xfer_buf), .cmd_done(cmd_done), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] mem [0:127];
  logic [31:0] alog [0:63];
  logic [31:0] blog [0:15];
  int acount = 0, bcount = 0, dcount = 0, go_cyc = 0, lat_last = 0;
  logic stall_mode = 1'b0, tgl = 1'b0;

  assign mrd_ready = stall_mode ? tgl : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tgl <= ~tgl;
    if (rst) begin
      mrd_rvalid <= 1'b0;
      mrd_rdata  <= '0;
    end else begin
      mrd_rvalid <= 1'b0;
      if (mrd_valid && mrd_ready) begin
        mrd_rvalid <= 1'b1;
        mrd_rdata  <= mem[mrd_addr[8:2]];
        if (acount < 64) alog[acount] <= mrd_addr;
        acount <= acount + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (xfer_go) begin
        if (bcount < 16) blog[bcount] = xfer_buf;
        bcount = bcount + 1;
        go_cyc = cyc;
      end
      if (cmd_done) begin
        dcount = dcount + 1;
        lat_last = cyc - go_cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_rd_sel = sel;
    @(posedge clk);
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 3000 && q < 4; i++) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic put(input int a, input logic [31:0] nx, input logic [31:0] ctl, input logic [31:0] bf);
    mem[a/4]     = nx;
    mem[a/4 + 1] = ctl;
    mem[a/4 + 2] = bf;
  endtask

  task automatic clr();
    acount = 0; bcount = 0; dcount = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(busy == 1'b0, "R8 busy after reset", busy, 0);
    chk(cmd_done == 1'b0, "R7 done after reset", cmd_done, 0);
    rd(1'b0, v); chk(v == 0, "R8 next addr after reset", v, 0);
    rd(1'b1, v); chk(v == 0, "R8 sema after reset", v, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    clr();
    put(32'h40, 32'h0, C_DEC, 32'hA000);
    wr(1'b0, 32'h40);
    wr(1'b1, 32'd1);
    wait_quiet();
    chk(acount == 3, "R1 word reads", acount, 3);
    chk(alog[0] == 32'h40 && alog[1] == 32'h44 && alog[2] == 32'h48, "R1 word order", alog[2], 32'h48);
    chk(bcount == 1 && blog[0] == 32'hA000, "R1 buffer on go", blog[0], 32'hA000);
    chk(dcount == 1, "R7 one done", dcount, 1);
    chk(lat_last == LAT, "R7 done latency", lat_last, LAT);
    rd(1'b1, v); chk(v == 0, "R3 decrement to zero", v, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    clr();
    put(32'h80, 32'h90, C_CHAIN | C_DEC, 32'hB001);
    put(32'h90, 32'hA0, C_CHAIN | C_DEC, 32'hB002);
    put(32'hA0, 32'h0,  C_DEC,           32'hB003);
    wr(1'b0, 32'h80);
    wr(1'b1, 32'd3);
    wait_quiet();
    chk(dcount == 3, "R4 chain length", dcount, 3);
    chk(blog[0] == 32'hB001 && blog[1] == 32'hB002 && blog[2] == 32'hB003, "R4 chain order", blog[2], 32'hB003);
    chk(alog[3] == 32'h90 && alog[6] == 32'hA0, "R4 follows pointer", alog[6], 32'hA0);
    rd(1'b0, v); chk(v == 32'hA0, "R4 next addr updated", v, 32'hA0);
  endtask

  task automatic t_sema_gate();
    logic [31:0] v;
    clr();
    put(32'hC0, 32'hD0, C_CHAIN | C_DEC, 32'hC001);
    put(32'hD0, 32'hE0, C_CHAIN | C_DEC, 32'hC002);
    put(32'hE0, 32'h0,  C_DEC,           32'hC003);
    wr(1'b0, 32'hC0);
    wr(1'b1, 32'd2);
    wait_quiet();
    repeat (40) @(negedge clk);
    chk(dcount == 2, "R2 stops at zero", dcount, 2);
    chk(acount == 6, "R2 no fetch at zero", acount, 6);
    rd(1'b0, v); chk(v == 32'hE0, "R2 next addr held", v, 32'hE0);
    wr(1'b1, 32'd1);
    wait_quiet();
    chk(dcount == 3 && blog[2] == 32'hC003, "R2 resume", blog[2], 32'hC003);
  endtask

  task automatic t_nodec();
    logic [31:0] v;
    clr();
    put(32'h100, 32'h110, C_CHAIN, 32'hD001);
    put(32'h110, 32'h0,   C_DEC,   32'hD002);
    wr(1'b0, 32'h100);
    wr(1'b1, 32'd1);
    wait_quiet();
    chk(dcount == 2, "R7 pulse without decrement", dcount, 2);
    rd(1'b1, v); chk(v == 0, "R3 only flagged decrement", v, 0);
  endtask

  task automatic t_chain_end();
    logic [31:0] v;
    clr();
    put(32'h120, 32'h0, C_DEC, 32'hE001);
    put(32'h130, 32'h0, C_DEC, 32'hE002);
    wr(1'b0, 32'h120);
    wr(1'b1, 32'd3);
    wait_quiet();
    repeat (40) @(negedge clk);
    chk(dcount == 1 && acount == 3, "R5 chain closed", dcount, 1);
    rd(1'b1, v); chk(v == 2, "R5 count left", v, 2);
    wr(1'b0, 32'h130);
    wait_quiet();
    chk(dcount == 2 && blog[1] == 32'hE002, "R5 rearm on rewrite", blog[1], 32'hE002);
    rd(1'b1, v); chk(v == 1, "R5 count after rearm", v, 1);
    wr(1'b0, 32'h130);
    wait_quiet();
    rd(1'b1, v); chk(v == 0, "R3 drained", v, 0);
  endtask

  task automatic t_add_running();
    logic [31:0] v;
    clr();
    put(32'h140, 32'h150, C_CHAIN | C_DEC, 32'hF001);
    put(32'h150, 32'h160, C_CHAIN | C_DEC, 32'hF002);
    put(32'h160, 32'h170, C_CHAIN | C_DEC, 32'hF003);
    put(32'h170, 32'h0,   C_DEC,           32'hF004);
    wr(1'b0, 32'h140);
    wr(1'b1, 32'd1);
    for (int i = 0; i < 200 && bcount == 0; i++) @(negedge clk);
    wr(1'b1, 32'd3);
    wait_quiet();
    chk(dcount == 4, "R6 add while running", dcount, 4);
    rd(1'b1, v); chk(v == 0, "R6 count after run", v, 0);
  endtask

  task automatic t_stall();
    clr();
    stall_mode = 1'b1;
    put(32'h180, 32'h190, C_CHAIN | C_DEC, 32'h5001);
    put(32'h190, 32'h0,   C_DEC,           32'h5002);
    wr(1'b0, 32'h180);
    wr(1'b1, 32'd2);
    wait_quiet();
    stall_mode = 1'b0;
    chk(acount == 6 && alog[5] == 32'h198 && alog[3] == 32'h190, "R9 addresses under stall", alog[5], 32'h198);
    chk(dcount == 2 && blog[1] == 32'h5002, "R9 commands under stall", blog[1], 32'h5002);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    wr(1'b1, 32'd200);
    rd(1'b1, v); chk(v == 200, "R6 add from zero", v, 200);
    wr(1'b1, 32'd100);
    rd(1'b1, v); chk(v == 255, "R6 saturate", v, 255);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); chk(v == 255, "R6 saturate wide", v, 255);
    chk(dcount == 2, "R5 idle while disarmed", dcount, 2);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_chain();
    t_sema_gate();
    t_nodec();
    t_chain_end();
    t_add_running();
    t_stall();
    t_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule